// File: doc/BRIEF.md
# Subvector Transpose Index Generator

This block walks a two-dimensional array of short subvectors, made of a count of elements (VL) each holding one to four subelements (SUBVL), and issues one pair of register offsets per clock: one offset for reading the source and one for writing the destination. The walk itself is always the same: the element counter is the outer loop and the subelement counter is the inner loop. Each side then turns the current (element, subelement) pair into a linear offset in one of two orders. In the normal order the subelements of one element sit next to each other. In the transposed order the subelement index selects a row of VL entries, so the array is read or written as its 2D transpose.

Two enables choose the order for each side separately. The unpack enable transposes the source side and the pack enable transposes the destination side. Setting just one of them gathers or scatters the subvector components. Setting both, or neither, gives a straight copy. The element step and the subelement step are also output, so that a later stage can remap the element index and leave the subelement index alone. A start pulse captures the configuration. The block then runs VL×SUBVL cycles and ends with a one-cycle done flag.

Top module: `subvec_xpose_idx`

## Requirements
- R1: After a synchronous reset, valid and done are 0, and both steps and both offsets are 0.
- R2: The subelement count SUBVL is the 2-bit code plus one: code 0 means 1 and code 3 means 4. A start accepted with VL>0 gives exactly VL×SUBVL consecutive cycles of valid. The first of these cycles is the cycle after the start edge.
- R3: The walk order is fixed. The subelement step counts from 0 to SUBVL-1 inside each element step, and the element step counts from 0 to VL-1.
- R4: A side in normal order outputs the offset element_step×SUBVL + sub_step.
- R5: A side in transposed order outputs the offset sub_step×VL + element_step.
- R6: The unpack enable selects the transposed order for the source offset only. The pack enable selects it for the destination offset only. When the two enables are equal, the two offsets are equal.
- R7: Done is high for exactly one cycle, in the cycle after the last valid pair. Valid and done are never high together.
- R8: VL, the code and the enables are captured when a start is accepted. Start is accepted only when neither valid nor done is high. A start pulse while valid or done is high has no effect, and input changes during a run have no effect.
- R9: A start with VL=0 produces no valid cycle. Done rises in the cycle after the start edge.
- R10: At the largest size, VL=64 with SUBVL=4, the block produces 256 pairs, and the last pair has offset 255 on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts a walk when the block is idle |
| vl_in | input | 7 | Element count, 0 to 64 |
| subvl_code | input | 2 | Subelement count minus one |
| pack_en | input | 1 | Transpose the destination offset |
| unpack_en | input | 1 | Transpose the source offset |
| el_step | output | 6 | Current element step |
| sub_step | output | 2 | Current subelement step |
| src_off | output | 8 | Linear source offset |
| dst_off | output | 8 | Linear destination offset |
| valid | output | 1 | Offset pair is valid this cycle |
| done | output | 1 | One-cycle pulse after the final pair |

## Verification
The assertions check these properties on every cycle:
- valid and done are never high together, and done lasts one cycle;
- done follows the final pair;
- both step counters stay below their limits, and both offsets stay below VL×SUBVL;
- the captured configuration stays unchanged during a run;
- the two offsets agree whenever both sides use the same order.

Only the bench scenarios can show the exact offset values in each order, the number of valid cycles, and that starts arriving during a run or during the done cycle are ignored. The same holds for the VL=0 and VL=64×4 extremes.

// File: rtl/subvec_pkg.sv
package subvec_pkg;

    localparam int SV_MAX_VL  = 64;
    localparam int SV_MAX_SUB = 4;
    localparam int SV_VL_W    = $clog2(SV_MAX_VL + 1);
    localparam int SV_EL_W    = $clog2(SV_MAX_VL);
    localparam int SV_SUB_W   = $clog2(SV_MAX_SUB);
    localparam int SV_OFF_W   = $clog2(SV_MAX_VL * SV_MAX_SUB);
    localparam int SV_SIDES   = 2;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_RUN,
        WALK_FIN
    } walk_state_e;

    typedef struct packed {
        logic [SV_VL_W-1:0]  vl;
        logic [SV_SUB_W-1:0] sub_code;
        logic                pack;
        logic                unpack;
    } walk_cfg_t;

    function automatic logic [SV_OFF_W:0] sv_total(input walk_cfg_t c);
        return (SV_OFF_W+1)'(c.vl) * ((SV_OFF_W+1)'(c.sub_code) + (SV_OFF_W+1)'(1));
    endfunction

endpackage

// File: rtl/subvec_loop_walker.sv
module subvec_loop_walker
    import subvec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  walk_cfg_t           cfg_in,
    output walk_cfg_t           cfg_q,
    output logic [SV_EL_W-1:0]  el_q,
    output logic [SV_SUB_W-1:0] sub_q,
    output logic                valid,
    output logic                done
);

    walk_state_e state_q;
    logic        last_sub;
    logic        last_el;

    assign last_sub = (sub_q == cfg_q.sub_code);
    assign last_el  = ({1'b0, el_q} == (cfg_q.vl - 1'b1));
    assign valid    = (state_q == WALK_RUN);
    assign done     = (state_q == WALK_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            cfg_q   <= '0;
            el_q    <= '0;
            sub_q   <= '0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        el_q    <= '0;
                        sub_q   <= '0;
                        state_q <= (cfg_in.vl == '0) ? WALK_FIN : WALK_RUN;
                    end
                end
                WALK_RUN: begin
                    if (last_sub) begin
                        sub_q <= '0;
                        if (last_el) begin
                            el_q    <= '0;
                            state_q <= WALK_FIN;
                        end else begin
                            el_q <= el_q + 1'b1;
                        end
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    assert_valid_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(valid && done));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && last_sub && last_el) |=> done);

    assert_el_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> ({1'b0, el_q} < cfg_q.vl));

    assert_sub_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sub_q <= cfg_q.sub_code));

    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid)) |-> $stable(cfg_q));

endmodule

// File: rtl/subvec_offset_calc.sv
module subvec_offset_calc
    import subvec_pkg::*;
(
    input  logic [SV_EL_W-1:0]  el,
    input  logic [SV_SUB_W-1:0] sub,
    input  logic [SV_VL_W-1:0]  vl,
    input  logic [SV_SUB_W-1:0] sub_code,
    input  logic                xpose,
    output logic [SV_OFF_W-1:0] off
);

    logic [SV_OFF_W-1:0] el_w, sub_w, vl_w, cnt_w;

    always_comb begin
        el_w  = SV_OFF_W'(el);
        sub_w = SV_OFF_W'(sub);
        vl_w  = SV_OFF_W'(vl);
        cnt_w = SV_OFF_W'(sub_code) + SV_OFF_W'(1);
        if (xpose) off = sub_w * vl_w + el_w;
        else       off = el_w * cnt_w + sub_w;
    end

endmodule

// File: rtl/subvec_xpose_idx.sv
module subvec_xpose_idx
    import subvec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SV_VL_W-1:0]  vl_in,
    input  logic [SV_SUB_W-1:0] subvl_code,
    input  logic                pack_en,
    input  logic                unpack_en,
    output logic [SV_EL_W-1:0]  el_step,
    output logic [SV_SUB_W-1:0] sub_step,
    output logic [SV_OFF_W-1:0] src_off,
    output logic [SV_OFF_W-1:0] dst_off,
    output logic                valid,
    output logic                done
);

    walk_cfg_t           cfg_in, cfg_q;
    logic [SV_OFF_W-1:0] side_off [SV_SIDES];
    logic [SV_OFF_W:0]   total;

    assign cfg_in = '{vl: vl_in, sub_code: subvl_code, pack: pack_en, unpack: unpack_en};

    subvec_loop_walker u_walker (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .el_q   (el_step),
        .sub_q  (sub_step),
        .valid  (valid),
        .done   (done)
    );

    // side 0 reads the source (unpack), side 1 writes the destination (pack)
    for (genvar gi = 0; gi < SV_SIDES; gi++) begin : g_side
        subvec_offset_calc u_calc (
            .el       (el_step),
            .sub      (sub_step),
            .vl       (cfg_q.vl),
            .sub_code (cfg_q.sub_code),
            .xpose    ((gi == 0) ? cfg_q.unpack : cfg_q.pack),
            .off      (side_off[gi])
        );
    end

    assign src_off = side_off[0];
    assign dst_off = side_off[1];
    assign total   = sv_total(cfg_q);

    assert_src_bound_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> ({1'b0, src_off} < total));

    assert_dst_bound_R5: assert property (@(posedge clk) disable iff (rst)
        valid |-> ({1'b0, dst_off} < total));

    assert_same_order_match_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && (cfg_q.pack == cfg_q.unpack)) |-> (src_off == dst_off));

endmodule

// File: tb/subvec_xpose_idx_bench.sv
module subvec_xpose_idx_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [6:0] vl_in;
    logic [1:0] subvl_code;
    logic       pack_en, unpack_en;
    logic [5:0] el_step;
    logic [1:0] sub_step;
    logic [7:0] src_off, dst_off;
    logic       valid, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    subvec_xpose_idx u_subvec_xpose_idx (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
        .subvl_code(subvl_code), .pack_en(pack_en), .unpack_en(unpack_en),
        .el_step(el_step), .sub_step(sub_step), .src_off(src_off),
        .dst_off(dst_off), .valid(valid), .done(done)
    );

    // {vl[6:0], code[1:0], pack, unpack}
    localparam logic [10:0] CASES [6] = '{
        {7'd3, 2'd1, 1'b0, 1'b0},
        {7'd3, 2'd1, 1'b0, 1'b1},
        {7'd3, 2'd1, 1'b1, 1'b0},
        {7'd4, 2'd2, 1'b1, 1'b1},
        {7'd1, 2'd0, 1'b0, 1'b0},
        {7'd5, 2'd3, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // runs one walk; poke_busy sends a second start mid-run (R8)
    task automatic run_case(input int vl, input int code, input bit pk, input bit up,
                            input bit poke_busy, input string tag);
        int n;
        int sv;
        @(negedge clk);
        vl_in = 7'(vl); subvl_code = 2'(code); pack_en = pk; unpack_en = up;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs: latched values must rule (R8)
        vl_in = 7'd2; subvl_code = 2'd0; pack_en = ~pk; unpack_en = ~up;
        sv = code + 1;
        n = 0;
        for (int e = 0; e < vl; e++) begin
            for (int s = 0; s < sv; s++) begin
                int es, ed;
                es = up ? (s * vl + e) : (e * sv + s);
                ed = pk ? (s * vl + e) : (e * sv + s);
                chk(valid === 1'b1 && done === 1'b0, {tag, " R2 valid"},
                    {valid, done}, 2'b10);
                chk(el_step == 6'(e) && sub_step == 2'(s), {tag, " R3 order"},
                    {el_step, sub_step}, {6'(e), 2'(s)});
                chk(src_off == 8'(es), {tag, up ? " R5 R6 src" : " R4 R6 src"},
                    src_off, es);
                chk(dst_off == 8'(ed), {tag, pk ? " R5 R6 dst" : " R4 R6 dst"},
                    dst_off, ed);
                if (poke_busy && n == 1) begin
                    vl_in = 7'd1; start = 1'b1;
                end
                n++;
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk(valid === 1'b0 && done === 1'b1, {tag, " R7 done after last"},
            {valid, done}, 2'b01);
        // start during the done cycle is ignored (R8)
        vl_in = 7'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(valid === 1'b0 && done === 1'b0, {tag, " R7 R8 done single, start ignored"},
            {valid, done}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; vl_in = '0; subvl_code = '0;
        pack_en = 1'b0; unpack_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0 && el_step == 0 && sub_step == 0
            && src_off == 0 && dst_off == 0, "R1 reset state",
            {valid, done, el_step, sub_step, src_off, dst_off}, 0);
        rst = 1'b0;

        foreach (CASES[i]) begin
            run_case(int'(CASES[i][10:4]), int'(CASES[i][3:2]), CASES[i][1], CASES[i][0],
                     1'b0, "table");
        end

        // R8: start pulse while busy
        run_case(4, 1, 1'b0, 1'b1, 1'b1, "busy start");

        // R9: VL of zero
        @(negedge clk);
        vl_in = 7'd0; subvl_code = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(valid === 1'b0 && done === 1'b1, "R9 vl0 done next cycle", {valid, done}, 2'b01);
        @(negedge clk);
        chk(valid === 1'b0 && done === 1'b0, "R9 vl0 no valid", {valid, done}, 2'b00);

        // R10: largest array in both single-sided orders
        run_case(64, 3, 1'b1, 1'b0, 1'b0, "R10 max pack");
        run_case(64, 3, 1'b0, 1'b1, 1'b0, "R10 max unpack");

        summary();
        $finish;
    end

endmodule